// File: doc/BRIEF.md
# Compare-Match Timer

The block is an up-counter that can be read and written over a register bus. It is meant for use inside a small controller-style peripheral. The count moves forward by one only in a cycle where the `tick` input is high. A separate clock-select block produces that one-cycle qualifier, so the timer runs at whatever rate software chose there. The timer has two event flags. One records the count wrapping from its all-ones value to zero. The other records the count stepping onto the value held in the match register. Each flag has its own interrupt enable. Software clears a flag either by writing a one to it or by pulsing the matching acknowledge input.

A two-bit pin mode field decides what the compare output pin does on each match event. The pin can toggle, be driven low, be driven high, or be left alone. In the last case the `pin_drive` output is low, which tells the surrounding port logic to keep its normal function.

The register bus is a plain synchronous write strobe with a combinational read mux. It has no valid/ready handshake and never stalls: a write lands at the next rising edge, and `bus_rdata` follows `bus_addr` in the same cycle. No streaming data passes through the block, so there is no back-pressure rule to obey.

Top module: `cmp_timer`

## Requirements
- R1: The count register (address 0) steps by one on each cycle with `tick` high and no count write, wraps from 255 to 0, and holds in every other cycle.
- R2: A tick that wraps the count from 255 to 0 sets the overflow flag, bit 0 of the flag register (address 3).
- R3: A tick that advances the count onto the match register value (address 1) sets the match flag, bit 1 of address 3. A stopped count or a software write of the count never sets it.
- R4: Pin mode is bits 1:0 of the control register (address 2) and acts on each match event: 00 leaves `cmp_pin` unchanged with `pin_drive` low, 01 toggles it, 10 drives it to 0, and 11 drives it to 1. `pin_drive` is high for any non-zero mode.
- R5: Writing address 3 clears each flag whose data bit is one. Flags whose data bit is zero are unaffected.
- R6: A one-cycle pulse on `ack_ovf` clears the overflow flag, and a pulse on `ack_cmp` clears the match flag.
- R7: `irq_ovf` is high while the overflow flag and its enable (control bit 2) are both set. `irq_cmp` is high while the match flag and its enable (control bit 3) are both set.
- R8: The count, match and control registers can be written at any time and read back over the bus. The flag register reads its two flags in bits 1:0. Unused bits read zero.
- R9: A count write wins over a tick in the same cycle, and the wrap that tick would have made does not set the overflow flag.
- R10: When a flag's set event and a clear request arrive in the same cycle, the flag ends up set.
- R11: After reset, count, match, control, both flags and `cmp_pin` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count qualifier from the clock-select block |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data of the addressed register |
| ack_ovf | input | 1 | Overflow interrupt acknowledge pulse |
| ack_cmp | input | 1 | Match interrupt acknowledge pulse |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Match interrupt request |
| cmp_pin | output | 1 | Compare output pin value |
| pin_drive | output | 1 | High when the timer owns the compare pin |

## Verification
The bench builds the block with its default 8-bit count. With that width a full wrap takes only 256 ticks, so the random phase reaches the 255-to-0 wrap many times. The match value then falls on every count value during the run. Random ticks, writes and acknowledges are mixed together, which brings collisions into reach: a count write landing on a wrapping tick, and a clear landing on a set event. Directed sequences walk through all four pin modes and both ways of clearing a flag.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_AW    = 2;
  localparam int NUM_FLAGS = 2;
  localparam int FLG_OVF   = 0;
  localparam int FLG_CMP   = 1;
  localparam int CTRL_OVF_EN = 2;
  localparam int CTRL_CMP_EN = 3;

  typedef enum logic [1:0] {
    PIN_KEEP   = 2'b00,
    PIN_TOGGLE = 2'b01,
    PIN_LOW    = 2'b10,
    PIN_HIGH   = 2'b11
  } pin_mode_e;

  typedef enum logic [REG_AW-1:0] {
    A_COUNT = 2'd0,
    A_MATCH = 2'd1,
    A_CTRL  = 2'd2,
    A_FLAGS = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt,
  output logic             match_evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             step;
  logic [CNT_W-1:0] next_cnt;

  // a load takes the cycle; the tick is dropped together with its events
  assign step     = tick & ~load;
  assign next_cnt = count + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= next_cnt;
  end

  assign wrap_evt  = step & (count == CNT_MAX);
  assign match_evt = step & (next_cnt == match_val);
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  // set beats clear so an event landing with a clear is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/tmr_pin.sv
module tmr_pin
  import tmr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode,
  input  logic      hit,
  output logic      pin,
  output logic      drive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else if (hit) begin
      unique case (mode)
        PIN_TOGGLE: pin <= ~pin;
        PIN_LOW:    pin <= 1'b0;
        PIN_HIGH:   pin <= 1'b1;
        default:    pin <= pin;
      endcase
    end
  end

  assign drive = (mode != PIN_KEEP);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ack_ovf,
  input  logic             ack_cmp,
  output logic             irq_ovf,
  output logic             irq_cmp,
  output logic             cmp_pin,
  output logic             pin_drive
);
  logic                 cnt_wr, match_wr, ctrl_wr, flag_wr;
  logic [CNT_W-1:0]     count_q, match_q;
  pin_mode_e            mode_q;
  logic                 ovf_en_q, cmp_en_q;
  logic                 wrap_evt, match_evt;
  logic [NUM_FLAGS-1:0] set_vec, ack_vec, flag_clr, flags_q;

  assign cnt_wr   = bus_wr & (bus_addr == A_COUNT);
  assign match_wr = bus_wr & (bus_addr == A_MATCH);
  assign ctrl_wr  = bus_wr & (bus_addr == A_CTRL);
  assign flag_wr  = bus_wr & (bus_addr == A_FLAGS);

  tmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .load      (cnt_wr),
    .load_val  (bus_wdata),
    .match_val (match_q),
    .count     (count_q),
    .wrap_evt  (wrap_evt),
    .match_evt (match_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q  <= '0;
      mode_q   <= PIN_KEEP;
      ovf_en_q <= 1'b0;
      cmp_en_q <= 1'b0;
    end else begin
      if (match_wr) match_q <= bus_wdata;
      if (ctrl_wr) begin
        mode_q   <= pin_mode_e'(bus_wdata[1:0]);
        ovf_en_q <= bus_wdata[CTRL_OVF_EN];
        cmp_en_q <= bus_wdata[CTRL_CMP_EN];
      end
    end
  end

  assign set_vec[FLG_OVF] = wrap_evt;
  assign set_vec[FLG_CMP] = match_evt;
  assign ack_vec[FLG_OVF] = ack_ovf;
  assign ack_vec[FLG_CMP] = ack_cmp;
  assign flag_clr = ack_vec | (flag_wr ? bus_wdata[NUM_FLAGS-1:0] : '0);

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    tmr_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (set_vec[g]),
      .clr   (flag_clr[g]),
      .flag  (flags_q[g])
    );
  end

  tmr_pin u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode_q),
    .hit   (match_evt),
    .pin   (cmp_pin),
    .drive (pin_drive)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_COUNT: bus_rdata = count_q;
      A_MATCH: bus_rdata = match_q;
      A_CTRL: begin
        bus_rdata[1:0]         = mode_q;
        bus_rdata[CTRL_OVF_EN] = ovf_en_q;
        bus_rdata[CTRL_CMP_EN] = cmp_en_q;
      end
      default: bus_rdata[NUM_FLAGS-1:0] = flags_q;
    endcase
  end

  assign irq_ovf = flags_q[FLG_OVF] & ovf_en_q;
  assign irq_cmp = flags_q[FLG_CMP] & cmp_en_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] match_q,
  input logic [1:0]       flags_q,
  input logic [1:0]       flag_clr,
  input logic [1:0]       mode_q,
  input logic             cmp_pin,
  input logic             ack_ovf,
  input logic             cmp_en_q,
  input logic             irq_cmp
);
  logic             adv, at_max, hits;
  logic [CNT_W-1:0] nxt;
  assign adv    = tick & ~cnt_wr;
  assign nxt    = CNT_W'(count_q + 1'b1);
  assign at_max = (count_q == {CNT_W{1'b1}});
  assign hits   = adv & (nxt == match_q);

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> count_q == CNT_W'($past(count_q) + 1'b1));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr) |=> $stable(count_q));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_max) |=> flags_q[0]);
  p_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hits |=> flags_q[1]);
  p_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !flags_q[1]) |=> !flags_q[1]);
  p_pin_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hits && mode_q == 2'b11) |=> cmp_pin);
  p_pin_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |=> $stable(cmp_pin));
  p_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ovf && !(adv && at_max)) |=> !flags_q[0]);
  p_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[1] && cmp_en_q) |-> irq_cmp);
  p_wprio_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !$rose(flags_q[0]));
  p_setwins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hits && flag_clr[1]) |=> flags_q[1]);
endmodule

bind cmp_timer tmr_checker #(.CNT_W(CNT_W)) u_tmr_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .cnt_wr   (cnt_wr),
  .count_q  (count_q),
  .match_q  (match_q),
  .flags_q  (flags_q),
  .flag_clr (flag_clr),
  .mode_q   (mode_q),
  .cmp_pin  (cmp_pin),
  .ack_ovf  (ack_ovf),
  .cmp_en_q (cmp_en_q),
  .irq_cmp  (irq_cmp)
);

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0, bus_wr = 1'b0, ack_ovf = 1'b0, ack_cmp = 1'b0;
  logic [1:0]   bus_addr = 2'd0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         irq_ovf, irq_cmp, cmp_pin, pin_drive;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference state
  int m_cnt, m_cmp, m_ctrl, m_ovf, m_cf, m_pin;

  always #10 clk = ~clk;

  cmp_timer #(.CNT_W(W)) u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack_ovf(ack_ovf), .ack_cmp(ack_cmp), .irq_ovf(irq_ovf),
    .irq_cmp(irq_cmp), .cmp_pin(cmp_pin), .pin_drive(pin_drive)
  );

  always @(posedge clk) begin
    int nc, wrap, hit, clr_o, clr_c;
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_ctrl = 0; m_ovf = 0; m_cf = 0; m_pin = 0;
    end else begin
      wrap = 0; hit = 0; nc = m_cnt;
      if (bus_wr && bus_addr == 0) nc = bus_wdata;
      else if (tick) begin
        nc = (m_cnt + 1) % 256;
        wrap = (m_cnt == 255);
        hit = (nc == m_cmp);
      end
      clr_o = ack_ovf || (bus_wr && bus_addr == 3 && bus_wdata[0]);
      clr_c = ack_cmp || (bus_wr && bus_addr == 3 && bus_wdata[1]);
      if (hit) begin
        if ((m_ctrl & 3) == 1) m_pin = 1 - m_pin;
        else if ((m_ctrl & 3) == 2) m_pin = 0;
        else if ((m_ctrl & 3) == 3) m_pin = 1;
      end
      m_ovf = wrap ? 1 : (clr_o ? 0 : m_ovf);
      m_cf  = hit  ? 1 : (clr_c ? 0 : m_cf);
      m_cnt = nc;
      if (bus_wr && bus_addr == 1) m_cmp = bus_wdata;
      if (bus_wr && bus_addr == 2) m_ctrl = bus_wdata & 15;
    end
  end

  function automatic int mread(int a);
    case (a)
      0: return m_cnt;
      1: return m_cmp;
      2: return m_ctrl;
      default: return m_cf * 2 + m_ovf;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R7 irq_ovf", 32'(irq_ovf), 32'(m_ovf & (m_ctrl >> 2) & 1));
    chk("R7 irq_cmp", 32'(irq_cmp), 32'(m_cf & (m_ctrl >> 3) & 1));
    chk("R4 cmp_pin", 32'(cmp_pin), 32'(m_pin));
    chk("R4 pin_drive", 32'(pin_drive), 32'((m_ctrl & 3) != 0));
    chk("R8 read", 32'(bus_rdata), 32'(mread(int'(bus_addr))));
  endtask

  task automatic cyc(bit t, bit w, bit [1:0] a, bit [7:0] d, bit ao, bit ac);
    tick = t; bus_wr = w; bus_addr = a; bus_wdata = d; ack_ovf = ao; ack_cmp = ac;
    @(posedge clk);
    @(negedge clk);
    cmp_all();
  endtask

  task automatic rd(bit [1:0] a, output int v);
    tick = 0; bus_wr = 0; ack_ovf = 0; ack_cmp = 0; bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, v); chk("R11 count", v, 0);
    rd(2, v); chk("R11 ctrl", v, 0);
    rd(3, v); chk("R11 flags", v, 0);
    chk("R11 pin", 32'(cmp_pin), 0);
    chk("R11 irq", 32'(irq_ovf | irq_cmp), 0);

    cyc(0, 1, 1, 5, 0, 0);
    cyc(0, 1, 2, 8'h0D, 0, 0);
    rd(1, v); chk("R8 match readback", v, 5);
    rd(2, v); chk("R8 ctrl readback", v, 13);
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0, 0, 0);
    rd(0, v); chk("R1 count after 4 ticks", v, 4);
    rd(3, v); chk("R3 no early match", v, 0);
    cyc(1, 0, 0, 0, 0, 0);
    rd(3, v); chk("R3 match flag", v, 2);
    chk("R4 toggle", 32'(cmp_pin), 1);
    chk("R7 irq_cmp", 32'(irq_cmp), 1);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, 0);
    rd(0, v); chk("R1 hold when idle", v, 5);
    cyc(0, 1, 3, 0, 0, 0);
    rd(3, v); chk("R5 zero bit keeps flag", v, 2);
    cyc(0, 1, 3, 2, 0, 0);
    rd(3, v); chk("R5 w1c clears", v, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0);
    rd(3, v); chk("R3 stopped no reset of flag", v, 0);
    cyc(0, 1, 0, 5, 0, 0);
    rd(3, v); chk("R3 write no match", v, 0);

    cyc(0, 1, 0, 8'hFE, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    rd(3, v); chk("R2 no flag at 255", v, 0);
    cyc(1, 0, 0, 0, 0, 0);
    rd(0, v); chk("R1 wrap to 0", v, 0);
    rd(3, v); chk("R2 overflow flag", v, 1);
    chk("R7 irq_ovf", 32'(irq_ovf), 1);
    cyc(0, 0, 0, 0, 1, 0);
    rd(3, v); chk("R6 ack_ovf clears", v, 0);

    cyc(0, 1, 0, 8'hFF, 0, 0);
    cyc(1, 1, 0, 8'h10, 0, 0);
    rd(0, v); chk("R9 write beats tick", v, 16);
    rd(3, v); chk("R9 no overflow", v, 0);

    cyc(0, 1, 0, 4, 0, 0);
    cyc(1, 1, 3, 2, 0, 0);
    rd(3, v); chk("R10 set beats clear", v, 2);
    chk("R4 toggle back", 32'(cmp_pin), 0);

    cyc(0, 1, 2, 8'h0F, 0, 0);
    cyc(0, 1, 0, 4, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R4 mode set", 32'(cmp_pin), 1);
    cyc(0, 1, 2, 8'h0C, 0, 0);
    chk("R4 keep drive low", 32'(pin_drive), 0);
    cyc(0, 1, 0, 4, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R4 keep unchanged", 32'(cmp_pin), 1);
    cyc(0, 1, 2, 8'h0E, 0, 0);
    cyc(0, 1, 0, 4, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    chk("R4 mode clear", 32'(cmp_pin), 0);
    cyc(0, 0, 0, 0, 0, 1);
    rd(3, v); chk("R6 ack_cmp clears", v, 0);

    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 6) == 0, 2'($urandom),
          8'($urandom), ($urandom % 16) == 0, ($urandom % 16) == 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule